// File: doc/BRIEF.md
# I2C Target Wake-on-Address Controller

This block lets an I2C target stay powered down while the chip sits in a deep low-power state. The I2C kernel clock stays off until the bus shows a START condition. The block then requests the internal oscillator and shifts in the 7-bit address that follows. If the address matches the programmed own address, the block raises a sticky address flag and a one-cycle wake pulse. It also holds SCL low from the next SCL falling edge until software acknowledges the flag. If the address does not match, the block withdraws the oscillator request and the system sleeps on.

Wake on address is usable only under all four of these conditions:

- wake is enabled;
- the internal oscillator, and not the system clock, is the kernel clock;
- clock stretching is enabled;
- the digital filter length is zero.

If the block is asked to sleep while the peripheral is still enabled and wake is not usable, it reports a configuration error. The bus inputs are taken as already synchronised to the oscillator clock. Data transfer after the address, the glitch filter and power sequencing are handled elsewhere.

Top module: `i2c_wake_ctl`

## Requirements
- R1: When armed (`sleep_req`=1, `periph_en`=1 and wake usable), a START (SDA falling while SCL is high) sets `osc_req` to 1 on the next clock. `osc_req` stays at 1 through the address phase.
- R2: Wake is usable only when `wake_en`=1, `clk_sel_sys`=0, `stretch_en`=1 and `filt_len`=0. In every other case a START leaves `osc_req`, `addr_flag` and `wake_pulse` at 0.
- R3: The address is the first 7 bits sampled on SCL rising edges after a START, most significant bit first. The 8th sampled bit is R/W and takes no part in the comparison.
- R4: An address equal to `own_addr` sets `addr_flag` and produces exactly one `wake_pulse` cycle. A `wake_pulse` never lasts two cycles.
- R5: After a match, `scl_drive_low` rises on the next SCL falling edge. It stays high until `addr_clr` and is 0 from the cycle after the strobe. `osc_req` stays at 1 after release.
- R6: A mismatching address returns `osc_req` to 0 within one cycle of the 8th rising edge. No flag, no wake pulse and no SCL stretch follow.
- R7: `addr_flag` stays at 1 until an `addr_clr` strobe, and is 0 on the cycle after the strobe.
- R8: A STOP (SDA rising while SCL is high) after the transfer returns `osc_req` to 0.
- R9: `cfg_err` equals, one cycle later, `sleep_req` AND `periph_en` AND NOT (wake usable).
- R10: While `rst_n` is 0, every output is 0 from the first clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL line level |
| sda_i | input | 1 | Synchronised SDA line level |
| wake_en | input | 1 | Wake-on-address enable |
| periph_en | input | 1 | Peripheral enable |
| stretch_en | input | 1 | Clock stretching enabled |
| clk_sel_sys | input | 1 | 1 when the system clock is the kernel clock |
| filt_len | input | FILT_W | Digital filter length setting |
| own_addr | input | ADDR_W | Programmed own address |
| sleep_req | input | 1 | Deep low-power state requested |
| addr_clr | input | 1 | One-cycle strobe clearing the address flag |
| scl_drive_low | output | 1 | Pull SCL low (stretch) |
| osc_req | output | 1 | Internal oscillator request |
| wake_pulse | output | 1 | One-cycle system wake event |
| addr_flag | output | 1 | Sticky address-match flag |
| cfg_err | output | 1 | Sleep requested with peripheral on but wake unusable |

## Verification
The bench builds the block with its default `ADDR_W`=7 and `FILT_W`=4. With a 7-bit address, every address on the bus can be tried against several own addresses, with the R/W bit toggled along the way. It also covers all 96 combinations of the five enable bits and three filter lengths, with the expected arming and error level computed from the usability formula. Every match case runs the full stretch-and-release sequence and the STOP that follows.

// File: rtl/i2cw_pkg.sv
// Shared types for the I2C wake-on-address controller.
package i2cw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,     // oscillator off, waiting for START
        ST_ADDR,     // shifting in the address byte
        ST_ACKWAIT,  // matched, waiting for SCL to fall
        ST_STRETCH,  // holding SCL low until software acknowledges
        ST_XFER      // transfer running, waiting for STOP
    } wk_state_t;
endpackage

// File: rtl/i2cw_busmon.sv
// Bus condition monitor.
// Compares the present SCL/SDA levels with the previous sample.
// Reports START, STOP and SCL rising/falling edges as one-cycle strobes.
// Assumes scl_i/sda_i are already synchronised to clk.
module i2cw_busmon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    logic scl_q, sda_q;

    // Keep the previous sample of both lines (idle bus is high).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Decode conditions from the level pair.
    always_comb begin
        start_o = scl_i && scl_q && sda_q && !sda_i;
        stop_o  = scl_i && scl_q && !sda_q && sda_i;
        rise_o  = scl_i && !scl_q;
        fall_o  = !scl_i && scl_q;
    end

    assert_start_stop_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_o && stop_o));
endmodule

// File: rtl/i2cw_addr_shift.sv
// Address shifter and comparator.
// Samples SDA on each SCL rising edge after a START, MSB first, until the
// address bits plus the R/W bit are in.
// Compares only the address bits with own_addr.
module i2cw_addr_shift #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              rise,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              frame_done,
    output logic              addr_hit
);
    localparam int FRAME_BITS = ADDR_W + 1;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    logic [FRAME_BITS-1:0] shreg;
    logic [CNT_W-1:0]      bit_cnt;

    // Count and shift bits, restarting on every START.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (clear) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (rise && (bit_cnt != CNT_W'(FRAME_BITS))) begin
            shreg   <= {shreg[FRAME_BITS-2:0], sda_i};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Frame complete and address comparison (R/W bit excluded).
    always_comb begin
        frame_done = (bit_cnt == CNT_W'(FRAME_BITS));
        addr_hit   = (shreg[FRAME_BITS-1:1] == own_addr);
    end

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(FRAME_BITS));
    assert_clear_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (bit_cnt == '0));
endmodule

// File: rtl/i2cw_fsm.sv
// Wake control sequencer.
// Requests the oscillator from START to the address decision.
// On a match: raises the flag and wake pulse, stretches SCL on the next falling
// edge until addr_clr, then keeps the oscillator until STOP.
// On a mismatch: drops straight back to idle.
module i2cw_fsm
    import i2cw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic start_det,
    input  logic stop_det,
    input  logic fall_det,
    input  logic frame_done,
    input  logic addr_hit,
    input  logic addr_clr,
    output logic osc_req,
    output logic scl_drive_low,
    output logic wake_pulse,
    output logic addr_flag
);
    wk_state_t state, state_nx;

    // Next-state decision.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start_det && armed) state_nx = ST_ADDR;
            ST_ADDR: begin
                if (start_det)       state_nx = armed ? ST_ADDR : ST_IDLE;
                else if (stop_det)   state_nx = ST_IDLE;
                else if (frame_done) state_nx = addr_hit ? ST_ACKWAIT : ST_IDLE;
            end
            ST_ACKWAIT: begin
                if (stop_det)      state_nx = ST_IDLE;
                else if (addr_clr) state_nx = ST_XFER;
                else if (fall_det) state_nx = ST_STRETCH;
            end
            ST_STRETCH: if (addr_clr) state_nx = ST_XFER;
            ST_XFER:    if (stop_det) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Wake pulse on the match decision, sticky flag until software clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_pulse <= 1'b0;
            addr_flag  <= 1'b0;
        end else begin
            wake_pulse <= (state == ST_ADDR) && (state_nx == ST_ACKWAIT);
            if (addr_clr)
                addr_flag <= 1'b0;
            else if ((state == ST_ADDR) && (state_nx == ST_ACKWAIT))
                addr_flag <= 1'b1;
        end
    end

    // Output decode.
    always_comb begin
        osc_req       = (state != ST_IDLE);
        scl_drive_low = (state == ST_STRETCH);
    end

    assert_no_start_unarmed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start_det && !armed) |=> !osc_req);
    assert_wake_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);
    assert_wake_has_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> (addr_flag && osc_req));
    assert_stretch_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        scl_drive_low |-> addr_flag);
    assert_miss_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && !start_det && !stop_det && frame_done && !addr_hit)
        |=> (!osc_req && !wake_pulse));
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_flag && !addr_clr) |=> addr_flag);
    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        addr_clr |=> !addr_flag);
endmodule

// File: rtl/i2c_wake_ctl.sv
// I2C target wake-on-address controller (top).
// Works out whether wake-on-address is usable, arms the sequencer while a
// sleep request is pending, and reports an unsafe sleep configuration.
// Assumes all inputs are synchronous to the oscillator clock clk.
module i2c_wake_ctl #(
    parameter int ADDR_W = 7,
    parameter int FILT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              wake_en,
    input  logic              periph_en,
    input  logic              stretch_en,
    input  logic              clk_sel_sys,
    input  logic [FILT_W-1:0] filt_len,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              sleep_req,
    input  logic              addr_clr,
    output logic              scl_drive_low,
    output logic              osc_req,
    output logic              wake_pulse,
    output logic              addr_flag,
    output logic              cfg_err
);
    logic usable, armed;
    logic start_det, stop_det, rise_det, fall_det;
    logic frame_done, addr_hit;

    // Wake usability and arming.
    always_comb begin
        usable = wake_en && !clk_sel_sys && stretch_en && (filt_len == '0);
        armed  = usable && sleep_req && periph_en;
    end

    // Flag an unsafe sleep entry one cycle after it appears.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_err <= 1'b0;
        else        cfg_err <= sleep_req && periph_en && !usable;
    end

    i2cw_busmon u_busmon (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .start_o(start_det), .stop_o(stop_det), .rise_o(rise_det), .fall_o(fall_det)
    );

    i2cw_addr_shift #(.ADDR_W(ADDR_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clear(start_det), .rise(rise_det),
        .sda_i(sda_i), .own_addr(own_addr),
        .frame_done(frame_done), .addr_hit(addr_hit)
    );

    i2cw_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .armed(armed), .start_det(start_det),
        .stop_det(stop_det), .fall_det(fall_det), .frame_done(frame_done),
        .addr_hit(addr_hit), .addr_clr(addr_clr), .osc_req(osc_req),
        .scl_drive_low(scl_drive_low), .wake_pulse(wake_pulse), .addr_flag(addr_flag)
    );

    assert_cfg_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && periph_en && !wake_en) |=> cfg_err);
endmodule

// File: tb/i2c_wake_ctl_tb.sv
`timescale 1ns/1ps
module i2c_wake_ctl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic wake_en, periph_en, stretch_en, clk_sel_sys, sleep_req, addr_clr;
    logic [3:0] filt_len;
    logic [6:0] own_addr;
    logic scl_drive_low, osc_req, wake_pulse, addr_flag, cfg_err;
    logic scl_line;

    int total = 0, bad = 0;
    int wake_cnt = 0, dbl_cnt = 0;
    logic wake_prev = 1'b0;
    int cyc = 0;

    always #4 clk = ~clk;
    assign scl_line = scl_m & ~scl_drive_low;   // wired-AND bus

    i2c_wake_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_m),
        .wake_en(wake_en), .periph_en(periph_en), .stretch_en(stretch_en),
        .clk_sel_sys(clk_sel_sys), .filt_len(filt_len), .own_addr(own_addr),
        .sleep_req(sleep_req), .addr_clr(addr_clr),
        .scl_drive_low(scl_drive_low), .osc_req(osc_req), .wake_pulse(wake_pulse),
        .addr_flag(addr_flag), .cfg_err(cfg_err)
    );

    // Count wake pulse cycles and back-to-back highs.
    always @(negedge clk) begin
        if (rst_n) begin
            if (wake_pulse) wake_cnt++;
            if (wake_pulse && wake_prev) dbl_cnt++;
        end
        wake_prev <= wake_pulse;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            bad++; total++;
            $display("FAIL watchdog (all) actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_start();
        scl_m = 1'b1; sda_m = 1'b1; tick(4);
        sda_m = 1'b0; tick(4);
        scl_m = 1'b0; tick(4);
    endtask

    task automatic send_bit(input logic b);
        scl_m = 1'b0; sda_m = b; tick(4);
        scl_m = 1'b1; tick(4);
    endtask

    task automatic send_stop();
        scl_m = 1'b0; sda_m = 1'b0; tick(4);
        scl_m = 1'b1; tick(4);
        sda_m = 1'b1; tick(4);
    endtask

    // One full address frame with expectations computed from R1-style rules.
    task automatic run_frame(input logic [6:0] a, input logic rw, input logic arm);
        int w0;
        int hit;
        w0 = wake_cnt;
        hit = (arm && a == own_addr) ? 1 : 0;
        send_start();
        check("R1/R2 osc after START", osc_req, arm);
        for (int i = 6; i >= 0; i--) send_bit(a[i]);
        send_bit(rw);
        check("R3/R6 osc after address", osc_req, hit);
        check("R4 flag on match", addr_flag, hit);
        check("R4 one wake pulse", wake_cnt - w0, hit);
        scl_m = 1'b0; tick(4);
        check("R5 stretch after fall", scl_drive_low, hit);
        if (hit == 1) begin
            tick(16);
            check("R7 flag held", addr_flag, 1);
            check("R5 stretch held", scl_drive_low, 1);
            addr_clr = 1'b1; tick(1);
            addr_clr = 1'b0;
            check("R7 flag cleared", addr_flag, 0);
            check("R5 stretch released", scl_drive_low, 0);
            check("R5 osc kept", osc_req, 1);
            tick(1);
        end else begin
            check("R6 no flag", addr_flag, 0);
        end
        send_stop();
        check("R8 osc off after STOP", osc_req, 0);
    endtask

    initial begin
        wake_en = 1; periph_en = 1; stretch_en = 1; clk_sel_sys = 0;
        sleep_req = 1; addr_clr = 0; filt_len = 0; own_addr = 7'h2A;
        tick(3);
        // R10: reset state
        check("R10 reset osc", osc_req, 0);
        check("R10 reset stretch", scl_drive_low, 0);
        check("R10 reset wake", wake_pulse, 0);
        check("R10 reset flag", addr_flag, 0);
        check("R10 reset cfg_err", cfg_err, 0);
        rst_n = 1'b1; tick(4);

        // R2/R9: configuration sweep with a matching address.
        for (int c = 0; c < 96; c++) begin
            logic [3:0] fl;
            logic use_ok, arm;
            wake_en     = c[0];
            periph_en   = c[1];
            stretch_en  = c[2];
            clk_sel_sys = c[3];
            sleep_req   = c[4];
            fl = (c / 32 == 0) ? 4'd0 : ((c / 32 == 1) ? 4'd1 : 4'd15);
            filt_len = fl;
            tick(2);
            use_ok = wake_en && !clk_sel_sys && stretch_en && (fl == 0);
            arm = use_ok && sleep_req && periph_en;
            check("R9 cfg_err", cfg_err, int'(sleep_req && periph_en && !use_ok));
            run_frame(own_addr, c[5], arm);
        end

        // R3/R4/R6: full address sweep against several own addresses.
        wake_en = 1; periph_en = 1; stretch_en = 1; clk_sel_sys = 0;
        sleep_req = 1; filt_len = 0;
        for (int o = 0; o < 3; o++) begin
            own_addr = (o == 0) ? 7'h00 : ((o == 1) ? 7'h55 : 7'h7F);
            tick(2);
            for (int a = 0; a < 128; a++) begin
                run_frame(7'(a), logic'((a >> 3) & 1), 1'b1);
            end
        end

        check("R4 no double-width pulse", dbl_cnt, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule